// File: doc/BRIEF.md
# Inter-Core Mailbox Register Bank

The block holds sixteen 32-bit mailboxes that processor cores use to signal each other. Each of the four cores owns four mailboxes. A mailbox is never written directly. A sender ORs bits into it through a write-one-to-set address, and the receiver removes bits through a write-one-to-clear address. Each mailbox drives a level interrupt toward its owning core. That line stays high for as long as any bit of the mailbox is set. Enabling and routing the interrupt happen elsewhere.

The bank has two independent write ports, A and B, so two bus masters can act in the same cycle. It also has one combinational read port. Mailbox `i = 4*core + box` is set at byte address `0x80 + 4*i` and cleared at byte address `0xC0 + 4*i`. In the address map, the core number therefore selects a 16-byte group and the box number selects a word inside that group.

Top module: `mbox_bank`

## Requirements
- R1: After reset, every mailbox reads zero and all sixteen bits of `mboxIrq` are low.
- R2: A write to set address `0x80 + 16*core + 4*box` ORs the write data into mailbox `4*core + box`. The change is visible from the next rising clock edge.
- R3: A write to clear address `0xC0 + 16*core + 4*box` clears the bits of that mailbox where the write data holds ones. All other bits keep their value.
- R4: `mboxIrq[i]` is high exactly when mailbox `i` is nonzero. Bit i is mailbox `4*core + box`.
- R5: Reading a clear address returns the current value of that mailbox. Reading a set address returns zero.
- R6: A write has no effect on any mailbox in two cases: the address is below `0x80`, or address bits [1:0] are nonzero. Any read of such an address returns zero.
- R7: Port A and port B may hit the same mailbox in one cycle, with one port setting and the other clearing. The new value is then `(old & ~clearData) | setData`, so the set wins on overlapping bits.
- R8: When both ports set the same mailbox in one cycle, both values are ORed in. When both ports clear the same mailbox in one cycle, both masks are applied.
- R9: A write to one mailbox leaves the other fifteen mailboxes unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEnA | input | 1 | Port A write strobe |
| wrAddrA | input | 8 | Port A byte address |
| wrDataA | input | 32 | Port A write data (set or clear mask) |
| wrEnB | input | 1 | Port B write strobe |
| wrAddrB | input | 8 | Port B byte address |
| wrDataB | input | 32 | Port B write data (set or clear mask) |
| rdAddr | input | 8 | Read byte address |
| rdData | output | 32 | Read data, combinational from `rdAddr` |
| mboxIrq | output | 16 | Level interrupt per mailbox, high while the mailbox is nonzero |

## Verification
The hardest case to reach is a set and a clear landing on the same mailbox in the same cycle with overlapping masks. One master on a bus cannot produce that case. The bench reaches it by driving ports A and B together on the same edge, in both port orders. It also drives the two ports with the same operation on one mailbox. The sweep visits every mailbox with masks unique to each index, so a wrong decode or a lost bit shows up on a neighbouring mailbox.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NUM_CORES    = 4;
  localparam int BOX_PER_CORE = 4;
  localparam int NBOX         = NUM_CORES * BOX_PER_CORE;
  localparam int DATA_W       = 32;
  localparam int IDX_W        = $clog2(NBOX);
  localparam int WIN_BYTES    = NBOX * 4;

  typedef logic [DATA_W-1:0] mbox_word_t;

  // Strobes from the decoder to the register datapath, one-hot per field
  typedef struct packed {
    logic [NBOX-1:0] setA;
    logic [NBOX-1:0] clrA;
    logic [NBOX-1:0] setB;
    logic [NBOX-1:0] clrB;
    logic [NBOX-1:0] rdSel;
  } mbox_strobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SET_BASE = 'h80,
  parameter int CLR_BASE = 'hC0
) (
  input  logic              wrEnA,
  input  logic [ADDR_W-1:0] wrAddrA,
  input  logic              wrEnB,
  input  logic [ADDR_W-1:0] wrAddrB,
  input  logic [ADDR_W-1:0] rdAddr,
  output mbox_strobe_t      strb
);
  // One-hot hit vector for an aligned address inside a window
  function automatic logic [NBOX-1:0] winHit(input logic [ADDR_W-1:0] addr, input int base);
    int a;
    int idx;
    logic [NBOX-1:0] res;
    res = '0;
    a   = int'(addr);
    if (addr[1:0] == 2'b00 && a >= base && a < base + WIN_BYTES) begin
      idx = (a - base) >> 2;
      res[idx] = 1'b1;
    end
    return res;
  endfunction

  logic [NBOX-1:0] setHitA, clrHitA, setHitB, clrHitB;

  always_comb begin
    setHitA = winHit(wrAddrA, SET_BASE);
    clrHitA = winHit(wrAddrA, CLR_BASE);
    setHitB = winHit(wrAddrB, SET_BASE);
    clrHitB = winHit(wrAddrB, CLR_BASE);
  end

  always_comb begin
    strb.setA  = wrEnA ? setHitA : '0;
    strb.clrA  = wrEnA ? clrHitA : '0;
    strb.setB  = wrEnB ? setHitB : '0;
    strb.clrB  = wrEnB ? clrHitB : '0;
    strb.rdSel = winHit(rdAddr, CLR_BASE);
  end
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  mbox_strobe_t    strb,
  input  mbox_word_t      wrDataA,
  input  mbox_word_t      wrDataB,
  output mbox_word_t      rdData,
  output logic [NBOX-1:0] mboxIrq
);
  mbox_word_t boxVal [NBOX];

  for (genvar gi = 0; gi < NBOX; gi++) begin : g_box
    mbox_word_t setMask, clrMask;
    logic       touch;

    always_comb begin
      setMask = (strb.setA[gi] ? wrDataA : '0) | (strb.setB[gi] ? wrDataB : '0);
      clrMask = (strb.clrA[gi] ? wrDataA : '0) | (strb.clrB[gi] ? wrDataB : '0);
      touch   = strb.setA[gi] | strb.setB[gi] | strb.clrA[gi] | strb.clrB[gi];
    end

    always_ff @(posedge clk) begin
      if (!rstN)      boxVal[gi] <= '0;
      else if (touch) boxVal[gi] <= (boxVal[gi] & ~clrMask) | setMask;
    end

    assign mboxIrq[gi] = |boxVal[gi];
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NBOX; i++)
      if (strb.rdSel[i]) rdData = rdData | boxVal[i];
  end
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SET_BASE = 'h80,
  parameter int CLR_BASE = 'hC0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEnA,
  input  logic [ADDR_W-1:0] wrAddrA,
  input  logic [31:0]       wrDataA,
  input  logic              wrEnB,
  input  logic [ADDR_W-1:0] wrAddrB,
  input  logic [31:0]       wrDataB,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic [15:0]       mboxIrq
);
  mbox_strobe_t strb;

  mbox_ctrl #(.ADDR_W(ADDR_W), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)) u_ctrl (
    .wrEnA(wrEnA), .wrAddrA(wrAddrA), .wrEnB(wrEnB), .wrAddrB(wrAddrB),
    .rdAddr(rdAddr), .strb(strb)
  );

  mbox_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrDataA(wrDataA), .wrDataB(wrDataB),
    .rdData(rdData), .mboxIrq(mboxIrq)
  );
endmodule

// File: rtl/mbox_bank_chk.sv
module mbox_bank_chk #(
  parameter int ADDR_W   = 8,
  parameter int SET_BASE = 'h80,
  parameter int CLR_BASE = 'hC0
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEnA,
  input logic [ADDR_W-1:0] wrAddrA,
  input logic [31:0]       wrDataA,
  input logic              wrEnB,
  input logic [ADDR_W-1:0] wrAddrB,
  input logic [31:0]       wrDataB,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [31:0]       rdData,
  input logic [15:0]       mboxIrq
);
  function automatic logic inWin(input logic [ADDR_W-1:0] a, input int base);
    return a[1:0] == 2'b00 && int'(a) >= base && int'(a) < base + 64;
  endfunction
  function automatic logic [3:0] idxOf(input logic [ADDR_W-1:0] a, input int base);
    int d;
    d = (int'(a) - base) >> 2;
    return d[3:0];
  endfunction

  logic       setHitA, clrHitA, setHitB, rdClrHit, rdSetHit;
  logic [3:0] idxA, idxB, rdIdx;
  always_comb begin
    setHitA  = wrEnA && inWin(wrAddrA, SET_BASE);
    clrHitA  = wrEnA && inWin(wrAddrA, CLR_BASE);
    setHitB  = wrEnB && inWin(wrAddrB, SET_BASE);
    idxA     = setHitA ? idxOf(wrAddrA, SET_BASE) : idxOf(wrAddrA, CLR_BASE);
    idxB     = idxOf(wrAddrB, SET_BASE);
    rdClrHit = inWin(rdAddr, CLR_BASE);
    rdSetHit = inWin(rdAddr, SET_BASE);
    rdIdx    = idxOf(rdAddr, CLR_BASE);
  end

  logic       prevSetNz, prevClrAll;
  logic [3:0] prevIdx;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSetNz  <= 1'b0;
      prevClrAll <= 1'b0;
      prevIdx    <= '0;
    end else begin
      prevSetNz  <= setHitA && wrDataA != '0;
      prevClrAll <= clrHitA && wrDataA == '1 &&
                    !(setHitB && idxB == idxA && wrDataB != '0);
      prevIdx    <= idxA;
    end
  end

  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rstN)
    prevSetNz |-> mboxIrq[prevIdx]); // R2
  AST_CLR_ALL_LOWERS: assert property (@(posedge clk) disable iff (!rstN)
    prevClrAll |-> !mboxIrq[prevIdx]); // R3
  AST_IRQ_MATCHES_VALUE: assert property (@(posedge clk) disable iff (!rstN)
    rdClrHit |-> (mboxIrq[rdIdx] == (rdData != '0))); // R4
  AST_SET_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdSetHit |-> rdData == '0); // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEnA && !wrEnB) |=> $stable(mboxIrq)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> mboxIrq == '0); // R1
endmodule

bind mbox_bank mbox_bank_chk #(.ADDR_W(ADDR_W), .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)) u_chk (
  .clk(clk), .rstN(rstN), .wrEnA(wrEnA), .wrAddrA(wrAddrA), .wrDataA(wrDataA),
  .wrEnB(wrEnB), .wrAddrB(wrAddrB), .wrDataB(wrDataB), .rdAddr(rdAddr),
  .rdData(rdData), .mboxIrq(mboxIrq)
);

// File: tb/mbox_bank_test.sv
module mbox_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEnA = 1'b0, wrEnB = 1'b0;
  logic [7:0]  wrAddrA = '0, wrAddrB = '0, rdAddr = '0;
  logic [31:0] wrDataA = '0, wrDataB = '0;
  logic [31:0] rdData;
  logic [15:0] mboxIrq;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp [16];

  always #10 clk = ~clk; // 50 MHz

  mbox_bank uut (
    .clk(clk), .rstN(rstN), .wrEnA(wrEnA), .wrAddrA(wrAddrA), .wrDataA(wrDataA),
    .wrEnB(wrEnB), .wrAddrB(wrAddrB), .wrDataB(wrDataB), .rdAddr(rdAddr),
    .rdData(rdData), .mboxIrq(mboxIrq)
  );

  function automatic logic [7:0] setAddr(input int i); return 8'(8'h80 + 4 * i); endfunction
  function automatic logic [7:0] clrAddr(input int i); return 8'(8'hC0 + 4 * i); endfunction
  function automatic logic [31:0] setPat(input int i);
    return (32'h1 << i) | (32'h1 << (31 - i)) | 32'h00F0_0000;
  endfunction
  function automatic logic [31:0] clrPat(input int i);
    return (32'h1 << i) | 32'h0030_0000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] want);
    checks++;
    if (act !== want) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, want);
    end
  endtask

  // One write cycle on either or both ports, then settle at the next falling edge
  task automatic cyc(input logic ea, input logic [7:0] aa, input logic [31:0] da,
                     input logic eb, input logic [7:0] ab, input logic [31:0] db);
    @(negedge clk);
    wrEnA = ea; wrAddrA = aa; wrDataA = da;
    wrEnB = eb; wrAddrB = ab; wrDataB = db;
    @(negedge clk);
    wrEnA = 1'b0; wrEnB = 1'b0;
  endtask

  task automatic checkAll(input string req);
    logic [15:0] irqExp;
    for (int i = 0; i < 16; i++) begin
      rdAddr = clrAddr(i);
      #1;
      check(req, rdData, exp[i]);
      irqExp[i] = exp[i] != '0;
    end
    check(req, {16'h0, mboxIrq}, {16'h0, irqExp});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) exp[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R2/R9: set each mailbox in turn, check all after each
    for (int i = 0; i < 16; i++) begin
      cyc(1'b1, setAddr(i), setPat(i), 1'b0, 8'h0, 32'h0);
      exp[i] |= setPat(i);
      checkAll("R2_R9");
    end
    // R2: OR accumulates
    cyc(1'b1, setAddr(5), 32'h0000_0F00, 1'b0, 8'h0, 32'h0);
    exp[5] |= 32'h0000_0F00;
    checkAll("R2");

    // R5: set addresses and out-of-window addresses read zero
    for (int i = 0; i < 16; i++) begin
      rdAddr = setAddr(i);
      #1;
      check("R5", rdData, 32'h0);
    end
    rdAddr = 8'h40; #1; check("R6", rdData, 32'h0);
    rdAddr = 8'hC1; #1; check("R6", rdData, 32'h0);

    // R6: writes below the windows and unaligned writes do nothing
    for (int a = 0; a < 8'h80; a += 4)
      cyc(1'b1, 8'(a), 32'hFFFF_FFFF, 1'b1, 8'(a), 32'hFFFF_FFFF);
    cyc(1'b1, 8'hC1, 32'hFFFF_FFFF, 1'b1, 8'h82, 32'hFFFF_FFFF);
    cyc(1'b1, 8'hCE, 32'hFFFF_FFFF, 1'b0, 8'h0, 32'h0);
    checkAll("R6");

    // R3/R9: partial clears
    for (int i = 0; i < 16; i++) begin
      cyc(1'b1, clrAddr(i), clrPat(i), 1'b0, 8'h0, 32'h0);
      exp[i] &= ~clrPat(i);
      checkAll("R3_R9");
    end

    // R7: A sets, B clears same mailbox, overlapping bits
    cyc(1'b1, setAddr(7), 32'h0000_00FF, 1'b1, clrAddr(7), 32'hFFFF_FFF0);
    exp[7] = (exp[7] & ~32'hFFFF_FFF0) | 32'h0000_00FF;
    checkAll("R7");
    // R7: port roles swapped
    cyc(1'b1, clrAddr(12), 32'hFFFF_FFFF, 1'b1, setAddr(12), 32'h8000_0001);
    exp[12] = 32'h8000_0001;
    checkAll("R7");

    // R8: both ports set, then both ports clear, same mailbox
    cyc(1'b1, setAddr(3), 32'h0A00_0000, 1'b1, setAddr(3), 32'h0050_0000);
    exp[3] |= 32'h0A50_0000;
    checkAll("R8");
    cyc(1'b1, clrAddr(3), 32'h0A00_0000, 1'b1, clrAddr(3), 32'h0050_0000);
    exp[3] &= ~32'h0A50_0000;
    checkAll("R8");

    // R4: clear every mailbox fully, interrupts drop
    for (int i = 0; i < 16; i += 2) begin
      cyc(1'b1, clrAddr(i), 32'hFFFF_FFFF, 1'b1, clrAddr(i + 1), 32'hFFFF_FFFF);
      exp[i] = '0;
      exp[i + 1] = '0;
    end
    checkAll("R4");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule